// File: doc/BRIEF.md
# Sliding Endpoint Buffer Allocator

This block keeps the start and end byte address of every endpoint's buffer inside one shared packet RAM. Each endpoint has a three-bit packet size code, a single/double bank select and a reservation request bit. Firmware reserves endpoints in rising number order. When a reservation bit goes up or down, the block recomputes addresses under a narrow sliding rule. The endpoint being changed is placed straight after the endpoint below it. Only the endpoint directly above it moves, and that endpoint's buffered data counts as lost. Every endpoint higher up keeps its old address, even when its region now overlaps a neighbour or leaves a gap.

The size of a region is fixed when the endpoint is reserved. It changes again only when the endpoint is released and reserved again. For each endpoint the block reports its base address, its end address (exclusive), a flag for a region that runs past the RAM, a flag for a usable configuration, and a sticky flag that marks a slide. Firmware clears the slide flag by rewriting that endpoint's configuration. The RAM, the transfer engine and endpoint enables are outside this block.

Top module: `ep_slide_alloc`

## Requirements
- R1: After reset every base and end address is 0 and the overflow, configuration-ok and data-lost flags are all low.
- R2: The region size is (8 << size_code) bytes when dual_bank is 0, and twice that when dual_bank is 1. size_code is 3 bits per endpoint, and endpoint j uses bits [3j+2:3j].
- R3: When reservation bit k rises, from the next clock edge endpoint k's base equals the end address of endpoint k-1 (0 for endpoint 0), and its end equals base plus region size.
- R4: When endpoint k is reserved and endpoint k+1 is already reserved, endpoint k+1's base moves to endpoint k's new end address and its data-lost flag is set.
- R5: When reservation bit k falls, endpoint k's end becomes equal to its base, which is unchanged. If endpoint k+1 is reserved, its base moves down to endpoint k's base and its data-lost flag is set.
- R6: Any reservation change on endpoint k leaves the base addresses of endpoints k+2 and above, and of endpoints below k, unchanged.
- R7: A reserved endpoint whose end address exceeds RAM_BYTES shows overflow high and configuration-ok low. A reserved endpoint that fits shows configuration-ok high and overflow low. An unreserved endpoint shows both low.
- R8: A one-cycle pulse on cfg_wr_i[j] clears data-lost flag j at the next edge. If a slide of endpoint j happens in the same cycle, the flag is set.
- R9: At most one reservation change takes effect per clock. When several request bits differ from the current state, the lowest-numbered endpoint is handled first.
- R10: A change to the size code or bank select of a reserved endpoint does not alter its end address until it is released and reserved again.
- R11: Reserving endpoint k while endpoint k+1 is unreserved leaves endpoint k+1's base unchanged and does not set its data-lost flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_i | input | NUM_EP | Reservation request bit per endpoint |
| size_code_i | input | 3*NUM_EP | Packet size code per endpoint, 8 << code bytes |
| dual_bank_i | input | NUM_EP | 1 selects two banks per endpoint |
| cfg_wr_i | input | NUM_EP | Configuration rewrite pulse, clears the data-lost flag |
| base_o | output | ADDR_W*NUM_EP | First byte address of each region |
| end_o | output | ADDR_W*NUM_EP | Address one past the last byte of each region |
| overflow_o | output | NUM_EP | Region runs past RAM_BYTES |
| cfg_ok_o | output | NUM_EP | Endpoint reserved and fits in the RAM |
| data_lost_o | output | NUM_EP | Endpoint was slid since its last configuration rewrite |

## Verification
On every cycle the assertions check these behaviours: at most one reservation bit changes per clock, a base address moves only when its own endpoint or the endpoint just below it is being handled, a data-lost flag rises only in the cycle after the endpoint below was handled, and a configuration rewrite clears the flag unless a slide happens at the same time. Some results depend on the history of reservations. These are the addresses produced by sequences of reserve and release, the overlap left when an endpoint two places up does not move, the order in which several pending changes are served, and the region size that stays fixed after the configuration is rewritten. Only the bench's scenarios can show them, by comparing against an arithmetic model.

// File: rtl/ep_alloc_pkg.sv
package ep_alloc_pkg;
   localparam int CODE_W     = 3;
   localparam int MIN_PKT    = 8;
   localparam int MAX_PKT    = MIN_PKT << ((1 << CODE_W) - 1);
   localparam int MAX_REGION = MAX_PKT * 2;
endpackage

// File: rtl/ep_region_size.sv
module ep_region_size #(
   parameter int  CODE_W       = 3,
   parameter int  OUT_W        = 14,
   parameter int  MIN_PKT      = 8,
   parameter bit  DUAL_BANK_EN = 1'b1
) (
   input  logic [CODE_W-1:0] code_i,
   input  logic              dual_i,
   output logic [OUT_W-1:0]  bytes_o
);
   logic [OUT_W-1:0] pkt;

   assign pkt = OUT_W'(MIN_PKT) << code_i;

   generate
      if (DUAL_BANK_EN) begin : g_dual
         assign bytes_o = dual_i ? (pkt << 1) : pkt;
      end else begin : g_single
         logic unused_dual;
         assign unused_dual = dual_i;
         assign bytes_o     = pkt;
      end
   endgenerate
endmodule

// File: rtl/ep_change_pick.sv
module ep_change_pick #(
   parameter int N     = 7,
   parameter int IDX_W = 3
) (
   input  logic [N-1:0]     req_i,
   output logic             vld_o,
   output logic [IDX_W-1:0] idx_o
);
   always_comb begin
      vld_o = 1'b0;
      idx_o = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req_i[i]) begin
            vld_o = 1'b1;
            idx_o = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/ep_slot.sv
module ep_slot #(
   parameter int ADDR_W = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              self_hit_i,
   input  logic              below_hit_i,
   input  logic              req_i,
   input  logic              below_req_i,
   input  logic [ADDR_W-1:0] new_base_i,
   input  logic [ADDR_W-1:0] req_size_i,
   input  logic [ADDR_W-1:0] below_new_end_i,
   input  logic [ADDR_W-1:0] below_base_i,
   input  logic              cfg_wr_i,
   output logic              alloc_o,
   output logic [ADDR_W-1:0] base_o,
   output logic [ADDR_W-1:0] size_o,
   output logic              lost_o
);
   logic slide;

   assign slide = below_hit_i && alloc_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         alloc_o <= 1'b0;
         base_o  <= '0;
         size_o  <= '0;
         lost_o  <= 1'b0;
      end else begin
         if (self_hit_i) begin
            alloc_o <= req_i;
            if (req_i) begin
               base_o <= new_base_i;
               size_o <= req_size_i;
            end else begin
               size_o <= '0;
            end
         end else if (slide) begin
            base_o <= below_req_i ? below_new_end_i : below_base_i;
         end
         if (slide) lost_o <= 1'b1;
         else if (cfg_wr_i) lost_o <= 1'b0;
      end
   end

   assert_alloc_base_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (self_hit_i && req_i) |=> (base_o == $past(new_base_i)));
   assert_free_size_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (self_hit_i && !req_i) |=> (size_o == '0));
   assert_base_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!self_hit_i && !below_hit_i) |=> $stable(base_o));
   assert_lost_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lost_o) |-> $past(below_hit_i));
   assert_lost_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr_i && !below_hit_i) |=> !lost_o);
endmodule

// File: rtl/ep_slide_alloc.sv
module ep_slide_alloc #(
   parameter int NUM_EP       = 7,
   parameter int RAM_BYTES    = 512,
   parameter bit DUAL_BANK_EN = 1'b1,
   localparam int CODE_W      = ep_alloc_pkg::CODE_W,
   localparam int ADDR_W      = $clog2(NUM_EP * ep_alloc_pkg::MAX_REGION + 1)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_EP-1:0]        alloc_i,
   input  logic [CODE_W*NUM_EP-1:0] size_code_i,
   input  logic [NUM_EP-1:0]        dual_bank_i,
   input  logic [NUM_EP-1:0]        cfg_wr_i,
   output logic [ADDR_W*NUM_EP-1:0] base_o,
   output logic [ADDR_W*NUM_EP-1:0] end_o,
   output logic [NUM_EP-1:0]        overflow_o,
   output logic [NUM_EP-1:0]        cfg_ok_o,
   output logic [NUM_EP-1:0]        data_lost_o
);
   localparam int IDX_W = $clog2(NUM_EP);

   generate
      if (NUM_EP < 2 || NUM_EP > 16) begin : g_bad_count
         $error("NUM_EP must lie in 2..16");
      end
      if (RAM_BYTES < ep_alloc_pkg::MIN_PKT || (RAM_BYTES % ep_alloc_pkg::MIN_PKT) != 0) begin : g_bad_ram
         $error("RAM_BYTES must be a nonzero multiple of the minimum packet");
      end
      if (RAM_BYTES > NUM_EP * ep_alloc_pkg::MAX_REGION) begin : g_big_ram
         $error("RAM_BYTES exceeds the address range");
      end
   endgenerate

   logic [NUM_EP-1:0] alloc_q;
   logic [NUM_EP-1:0] chg;
   logic              pick_vld;
   logic [IDX_W-1:0]  pick_idx;
   logic [ADDR_W-1:0] base_q   [NUM_EP];
   logic [ADDR_W-1:0] size_q   [NUM_EP];
   logic [ADDR_W-1:0] end_w    [NUM_EP];
   logic [ADDR_W-1:0] req_size [NUM_EP];
   logic [ADDR_W-1:0] new_base [NUM_EP];
   logic [ADDR_W-1:0] new_end  [NUM_EP];

   assign chg = alloc_i ^ alloc_q;

   ep_change_pick #(.N(NUM_EP), .IDX_W(IDX_W)) u_pick (
      .req_i (chg),
      .vld_o (pick_vld),
      .idx_o (pick_idx)
   );

   for (genvar j = 0; j < NUM_EP; j++) begin : g_ep
      logic self_hit;

      ep_region_size #(
         .CODE_W      (CODE_W),
         .OUT_W       (ADDR_W),
         .MIN_PKT     (ep_alloc_pkg::MIN_PKT),
         .DUAL_BANK_EN(DUAL_BANK_EN)
      ) u_size (
         .code_i  (size_code_i[j*CODE_W +: CODE_W]),
         .dual_i  (dual_bank_i[j]),
         .bytes_o (req_size[j])
      );

      assign self_hit   = pick_vld && (pick_idx == IDX_W'(j));
      assign end_w[j]   = base_q[j] + size_q[j];
      assign new_end[j] = new_base[j] + req_size[j];

      if (j == 0) begin : g_first
         assign new_base[j] = '0;
         ep_slot #(.ADDR_W(ADDR_W)) u_slot (
            .clk             (clk),
            .rst_n           (rst_n),
            .self_hit_i      (self_hit),
            .below_hit_i     (1'b0),
            .req_i           (alloc_i[j]),
            .below_req_i     (1'b0),
            .new_base_i      (new_base[j]),
            .req_size_i      (req_size[j]),
            .below_new_end_i ('0),
            .below_base_i    ('0),
            .cfg_wr_i        (cfg_wr_i[j]),
            .alloc_o         (alloc_q[j]),
            .base_o          (base_q[j]),
            .size_o          (size_q[j]),
            .lost_o          (data_lost_o[j])
         );
      end else begin : g_upper
         logic below_hit;
         assign new_base[j] = end_w[j-1];
         assign below_hit   = pick_vld && (pick_idx == IDX_W'(j - 1));
         ep_slot #(.ADDR_W(ADDR_W)) u_slot (
            .clk             (clk),
            .rst_n           (rst_n),
            .self_hit_i      (self_hit),
            .below_hit_i     (below_hit),
            .req_i           (alloc_i[j]),
            .below_req_i     (alloc_i[j-1]),
            .new_base_i      (new_base[j]),
            .req_size_i      (req_size[j]),
            .below_new_end_i (new_end[j-1]),
            .below_base_i    (base_q[j-1]),
            .cfg_wr_i        (cfg_wr_i[j]),
            .alloc_o         (alloc_q[j]),
            .base_o          (base_q[j]),
            .size_o          (size_q[j]),
            .lost_o          (data_lost_o[j])
         );
      end

      assign base_o[j*ADDR_W +: ADDR_W] = base_q[j];
      assign end_o[j*ADDR_W +: ADDR_W]  = end_w[j];
      assign overflow_o[j] = alloc_q[j] && (end_w[j] > ADDR_W'(RAM_BYTES));
      assign cfg_ok_o[j]   = alloc_q[j] && (end_w[j] <= ADDR_W'(RAM_BYTES));
   end

   assert_one_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(alloc_q ^ $past(alloc_q)) <= 1);
   assert_ep0_origin_R3: assert property (@(posedge clk) disable iff (!rst_n)
      base_o[ADDR_W-1:0] == '0);
   assert_flag_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (overflow_o & cfg_ok_o) == '0);
endmodule

// File: tb/ep_slide_alloc_tb.sv
`timescale 1ns/1ps
module ep_slide_alloc_tb;
   localparam int N   = 7;
   localparam int RAM = 512;
   localparam int AW  = $clog2(N * 2048 + 1);

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [N-1:0]    alloc_d = '0;
   logic [3*N-1:0]  code_d = '0;
   logic [N-1:0]    dual_d = '0;
   logic [N-1:0]    cfgwr_d = '0;
   logic [AW*N-1:0] base_w, end_w;
   logic [N-1:0]    ovf_w, ok_w, lost_w;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   int mb [N];
   int ms [N];
   bit ma [N];
   bit ml [N];

   always #2 clk = ~clk;

   ep_slide_alloc u_dut (
      .clk(clk), .rst_n(rst_n), .alloc_i(alloc_d), .size_code_i(code_d),
      .dual_bank_i(dual_d), .cfg_wr_i(cfgwr_d), .base_o(base_w), .end_o(end_w),
      .overflow_o(ovf_w), .cfg_ok_o(ok_w), .data_lost_o(lost_w)
   );

   task automatic cmp(string tag, string what, int ep, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s ep%0d %s: actual %0d expected %0d", tag, ep, what, act, exp);
      end
   endtask

   task automatic check_all(string tag);
      for (int j = 0; j < N; j++) begin
         int e;
         e = mb[j] + ms[j];
         cmp(tag, "base", j, int'(base_w[j*AW +: AW]), mb[j]);
         cmp(tag, "end", j, int'(end_w[j*AW +: AW]), e);
         cmp(tag, "overflow", j, int'(ovf_w[j]), int'(ma[j] && e > RAM));
         cmp(tag, "cfg_ok", j, int'(ok_w[j]), int'(ma[j] && e <= RAM));
         cmp(tag, "lost", j, int'(lost_w[j]), int'(ml[j]));
      end
   endtask

   // Arithmetic model of one clock edge, taken from the requirements.
   function automatic void model_step();
      int k;
      k = -1;
      for (int j = 0; j < N; j++) if (cfgwr_d[j]) ml[j] = 1'b0;
      for (int j = N - 1; j >= 0; j--) if (alloc_d[j] != ma[j]) k = j;
      if (k < 0) return;
      if (alloc_d[k]) begin
         int nb;
         nb = (k == 0) ? 0 : mb[k-1] + ms[k-1];
         mb[k] = nb;
         ms[k] = (8 << code_d[3*k +: 3]) * (dual_d[k] ? 2 : 1);
         ma[k] = 1'b1;
         if (k < N - 1 && ma[k+1]) begin
            mb[k+1] = nb + ms[k];
            ml[k+1] = 1'b1;
         end
      end else begin
         ms[k] = 0;
         ma[k] = 1'b0;
         if (k < N - 1 && ma[k+1]) begin
            mb[k+1] = mb[k];
            ml[k+1] = 1'b1;
         end
      end
   endfunction

   task automatic tick();
      model_step();
      @(negedge clk);
      cfgwr_d = '0;
   endtask

   task automatic set_cfg(int ep, int code, bit dual);
      code_d[3*ep +: 3] = 3'(code);
      dual_d[ep] = dual;
   endtask

   initial begin
      for (int j = 0; j < N; j++) begin
         mb[j] = 0; ms[j] = 0; ma[j] = 0; ml[j] = 0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R1");

      // Sweep every size code and bank choice on endpoint 0.
      for (int c = 0; c < 8; c++) begin
         for (int d = 0; d < 2; d++) begin
            set_cfg(0, c, d[0]);
            alloc_d[0] = 1'b1;
            tick();
            check_all("R2");
            cmp("R2", "size", 0, int'(end_w[AW-1:0]), (8 << c) * (d + 1));
            alloc_d[0] = 1'b0;
            tick();
            check_all("R5");
         end
      end

      // Reserve in rising order; upper neighbour is still free (R11).
      for (int j = 0; j < N; j++) begin
         set_cfg(j, j % 3, j[0]);
         alloc_d[j] = 1'b1;
         tick();
         check_all(j == N - 1 ? "R3" : "R11");
      end

      // Release endpoint 2: endpoint 3 slides down, 4 keeps its base.
      begin
         int b4;
         b4 = int'(base_w[4*AW +: AW]);
         alloc_d[2] = 1'b0;
         tick();
         check_all("R5");
         cmp("R6", "base", 4, int'(base_w[4*AW +: AW]), b4);
      end

      cfgwr_d[3] = 1'b1;
      tick();
      check_all("R8");

      // Re-reserve endpoint 2 larger: endpoint 3 slides up, 4 stays put.
      begin
         int b4;
         b4 = int'(base_w[4*AW +: AW]);
         set_cfg(2, 4, 1'b0);
         alloc_d[2] = 1'b1;
         tick();
         check_all("R4");
         cmp("R6", "base", 4, int'(base_w[4*AW +: AW]), b4);
      end

      // Rewrite configuration of a reserved endpoint.
      begin
         int e5;
         e5 = int'(end_w[5*AW +: AW]);
         set_cfg(5, 7, 1'b1);
         tick();
         check_all("R10");
         cmp("R10", "end", 5, int'(end_w[5*AW +: AW]), e5);
         set_cfg(5, 1, 1'b0);
      end

      // Two pending changes: lowest first, one per clock.
      alloc_d[1] = 1'b0;
      alloc_d[5] = 1'b0;
      tick();
      check_all("R9");
      cmp("R9", "cfg_ok", 5, int'(ok_w[5]), 1);
      tick();
      check_all("R9");

      // Slide and rewrite pulse in the same cycle: slide wins.
      cfgwr_d[2] = 1'b1;
      alloc_d[1] = 1'b1;
      tick();
      check_all("R8");
      cmp("R8", "lost", 2, int'(lost_w[2]), 1);

      // Oversized region on endpoint 6.
      alloc_d[6] = 1'b0;
      tick();
      check_all("R5");
      set_cfg(6, 6, 1'b1);
      alloc_d[6] = 1'b1;
      tick();
      check_all("R7");
      cmp("R7", "overflow", 6, int'(ovf_w[6]), 1);

      // Shrink it back so it fits.
      alloc_d[6] = 1'b0;
      tick();
      set_cfg(6, 3, 1'b0);
      alloc_d[6] = 1'b1;
      tick();
      check_all("R7");

      // Release everything at once, served lowest first.
      alloc_d = '0;
      for (int i = 0; i < N; i++) begin
         tick();
         check_all("R9");
      end

      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule